// File: doc/BRIEF.md
# Bit-Shuffle and Byte-Align Unit

This execution unit rearranges bits and bytes of 64-bit operands for a 64-bit processor pipeline. Each cycle it can accept one operation: a leading-zero count of a word, a bit-field extract, a per-byte bit reversal on a word or a doubleword, or a byte-granular funnel that joins the top bytes of one operand with the bottom bytes of the other. Word-sized results are sign-extended to 64 bits.

The issuing stage presents two source operands (`rs`, `rt`), a 4-bit operation code, a 3-bit byte position and two 5-bit field bounds, and it pulses `start`. One cycle later `res_valid` rises with the result. Codes that name byte-swap or sign-extend sub-operations, and codes with no meaning, are not executed. For these the unit raises `illegal` along with `res_valid` and returns zero. A new operation may be issued on every cycle.

Top module: `bitmix_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `res_valid` and `illegal`. Both stay low while `rst` is high.
- R2: When `start` is sampled high on a clock edge, `res_valid` is high after that edge and `res_data` carries the result. A cycle without `start` gives `res_valid` low. Operations issued on back-to-back cycles each produce their own result on consecutive cycles.
- R3: Op 0 (leading-zero count) counts the leading zeros of `rs[31:0]` and returns the count zero-extended to 64 bits. It returns 32 when that word is zero. `rs[63:32]` has no effect.
- R4: Op 1 (extract) returns `rs` shifted right by `flsb` and then masked to `fmsb+1` bits, zero-extended. Field widths from 1 to 32 bits are supported.
- R5: Op 2 (word bit swap) reverses the bit order inside each of the bytes of `rt[31:0]` and leaves each byte in its place. The 32-bit result is sign-extended, and `rt[63:32]` has no effect.
- R6: Op 3 (doubleword bit swap) reverses the bit order inside each of the eight bytes of `rt`, with no byte moved.
- R7: Op 4 (word align) uses `bpos[1:0]` as a byte count b, and `bpos[2]` is ignored. When b is 0 the result is `rt[31:0]` sign-extended.
- R8: Op 4 with b nonzero gives a word whose upper 32-8b bits are `rt[31-8b:0]` and whose lower 8b bits are `rs[31:32-8b]`. That word is sign-extended to 64 bits.
- R9: Op 5 (doubleword align) uses `bpos[2:0]` as b. When b is 0 the result is `rt`. Otherwise it is `rt[63-8b:0]` joined with `rs[63:64-8b]`.
- R10: Ops 6 to 15 are not executed. Codes 6 to 10 are the byte-swap and sign-extend sub-operations and codes 11 to 15 are unassigned. For any of them `illegal` is high with `res_valid` and `res_data` is zero. `illegal` is low for ops 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue strobe for the operation on the inputs |
| op | input | 4 | Operation code (see requirements) |
| rs | input | 64 | First source operand |
| rt | input | 64 | Second source operand |
| bpos | input | 3 | Byte position for the align operations |
| fmsb | input | 5 | Extract field size minus one |
| flsb | input | 5 | Extract field start bit |
| res_valid | output | 1 | Result strobe, one cycle after start |
| res_data | output | 64 | Result |
| illegal | output | 1 | Operation code not executed |

## Verification
The only state is the single output register, so any fault in it appears on the very next cycle. A missing or extra `res_valid` causes the scoreboard queue to fall out of step, and a stale or mixed `res_data` shows up as a mismatch on the operation that follows. A wrong `illegal` is seen in the same cycle as its result. Datapath faults are exposed by operand patterns whose bytes are asymmetric, by all-zero and sign-bit words, by every non-trivial byte position, and by upper halves that must be ignored.

// File: rtl/bitmix_pkg.sv
package bitmix_pkg;
  localparam int DATA_W = 64;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CLZ     = 4'd0,
    OP_EXTRACT = 4'd1,
    OP_BREV32  = 4'd2,
    OP_BREV64  = 4'd3,
    OP_ALN32   = 4'd4,
    OP_ALN64   = 4'd5,
    OP_SXB     = 4'd6,
    OP_SXH     = 4'd7,
    OP_HSWAP   = 4'd8,
    OP_DHSWAP  = 4'd9,
    OP_DWSWAP  = 4'd10
  } op_e;
endpackage

// File: rtl/bitmix_bitrev.sv
module bitmix_bitrev #(
  parameter int W = 64
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign dout[8*b+i] = din[8*b+7-i];
    end
  end

  // R5 / R6: reversal within bytes keeps the number of set bits
  always_comb begin
    a_r6_popcount_kept: assert ($countones(dout) == $countones(din));
  end
endmodule

// File: rtl/bitmix_align.sv
module bitmix_align #(
  parameter int W = 64
) (
  input  logic [W-1:0]                rs,
  input  logic [W-1:0]                rt,
  input  logic [$clog2(W/8)-1:0]      bp,
  output logic [W-1:0]                dout
);
  localparam int BPW = $clog2(W/8);

  logic [$clog2(W):0] lsh;
  logic [$clog2(W):0] rsh;

  always_comb begin
    lsh  = {{($clog2(W)+1-BPW-3){1'b0}}, bp, 3'b000};
    rsh  = ($clog2(W)+1)'(W) - lsh;
    if (bp == '0) dout = rt;
    else          dout = (rt << lsh) | (rs >> rsh);
  end
endmodule

// File: rtl/bitmix_clz.sv
module bitmix_clz #(
  parameter int W = 32
) (
  input  logic [W-1:0]           word,
  output logic [$clog2(W):0]     cnt
);
  localparam int CW = $clog2(W) + 1;

  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (word[i]) cnt = CW'(W - 1 - i);
    end
  end

  // R3: a nonzero word has its top set bit right below the counted zeros
  always_comb begin
    if (word != '0 && cnt < CW'(W)) begin
      a_r3_lead_bit_set: assert (word[W - 1 - int'(cnt)]);
    end
  end
endmodule

// File: rtl/bitmix_unit.sv
module bitmix_unit
  import bitmix_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int OW = OP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [OW-1:0]           op,
  input  logic [DW-1:0]           rs,
  input  logic [DW-1:0]           rt,
  input  logic [$clog2(DW/8)-1:0] bpos,
  input  logic [$clog2(DW/2)-1:0] fmsb,
  input  logic [$clog2(DW/2)-1:0] flsb,
  output logic                    res_valid,
  output logic [DW-1:0]           res_data,
  output logic                    illegal
);
  localparam int HW  = DW / 2;
  localparam int FW  = $clog2(HW);
  localparam int CW  = FW + 1;
  localparam int BPH = $clog2(HW/8);

  logic [HW-1:0] brev_w;
  logic [DW-1:0] brev_d;
  logic [HW-1:0] aln_w;
  logic [DW-1:0] aln_d;
  logic [CW-1:0] lz_cnt;

  bitmix_bitrev #(.W(HW)) u_brev_w (.din(rt[HW-1:0]), .dout(brev_w));
  bitmix_bitrev #(.W(DW)) u_brev_d (.din(rt), .dout(brev_d));

  bitmix_align #(.W(HW)) u_aln_w (
    .rs(rs[HW-1:0]), .rt(rt[HW-1:0]), .bp(bpos[BPH-1:0]), .dout(aln_w));
  bitmix_align #(.W(DW)) u_aln_d (
    .rs(rs), .rt(rt), .bp(bpos), .dout(aln_d));

  bitmix_clz #(.W(HW)) u_clz (.word(rs[HW-1:0]), .cnt(lz_cnt));

  // bit-field extract
  logic [FW:0]   fsize;
  logic [DW-1:0] fmask;
  logic [DW-1:0] ext_val;

  always_comb begin
    fsize   = {1'b0, fmsb} + {{FW{1'b0}}, 1'b1};
    fmask   = (DW'(1) << fsize) - DW'(1);
    ext_val = (rs >> flsb) & fmask;
  end

  logic [DW-1:0] res_c;
  logic          ill_c;

  always_comb begin
    res_c = '0;
    ill_c = 1'b0;
    case (op)
      OP_CLZ:     res_c = {{(DW-CW){1'b0}}, lz_cnt};
      OP_EXTRACT: res_c = ext_val;
      OP_BREV32:  res_c = {{HW{brev_w[HW-1]}}, brev_w};
      OP_BREV64:  res_c = brev_d;
      OP_ALN32:   res_c = {{HW{aln_w[HW-1]}}, aln_w};
      OP_ALN64:   res_c = aln_d;
      default:    ill_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= start;
      illegal   <= start & ill_c;
      if (start) res_data <= res_c;
    end
  end

  // R1: reset leaves both flags low
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && !illegal));

  // R2: one result per issue, one cycle later
  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);

  // R10: rejected operations are flagged with a zero result
  a_r10_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (res_valid && res_data == '0));
endmodule

// File: tb/bitmix_unit_tb.sv
module bitmix_unit_tb;
  localparam int DW = 64;

  typedef struct {
    logic [63:0] data;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] rs = '0, rt = '0;
  logic [2:0]  bpos = '0;
  logic [4:0]  fmsb = '0, flsb = '0;
  logic        res_valid, illegal;
  logic [63:0] res_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  always #10 clk = ~clk;

  bitmix_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .rs(rs), .rt(rt),
    .bpos(bpos), .fmsb(fmsb), .flsb(flsb),
    .res_valid(res_valid), .res_data(res_data), .illegal(illegal));

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++) y[7-i] = x[i];
    return y;
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [63:0] a,
                                 input logic [63:0] t, input logic [2:0] bp,
                                 input logic [4:0] hi, input logic [4:0] lo);
    exp_t e;
    logic [31:0] w;
    logic [63:0] d;
    int n;
    e.data = '0;
    e.ill  = 1'b0;
    case (o)
      4'd0: begin
        n = 0;
        for (int i = 31; i >= 0; i--) begin
          if (a[i]) break;
          n++;
        end
        e.data = 64'(n);
      end
      4'd1: begin
        d = '0;
        for (int i = 0; i <= int'(hi); i++) d[i] = (int'(lo) + i < 64) ? a[int'(lo) + i] : 1'b0;
        e.data = d;
      end
      4'd2: begin
        for (int k = 0; k < 4; k++) w[8*k +: 8] = rev8(t[8*k +: 8]);
        e.data = sx32(w);
      end
      4'd3: for (int k = 0; k < 8; k++) e.data[8*k +: 8] = rev8(t[8*k +: 8]);
      4'd4: begin
        n = int'(bp[1:0]);
        for (int k = 0; k < 4; k++)
          w[8*k +: 8] = (k < n) ? a[8*(4-n+k) +: 8] : t[8*(k-n) +: 8];
        e.data = sx32(w);
      end
      4'd5: begin
        n = int'(bp);
        for (int k = 0; k < 8; k++)
          e.data[8*k +: 8] = (k < n) ? a[8*(8-n+k) +: 8] : t[8*(k-n) +: 8];
      end
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [3:0] o, input logic [63:0] a,
                       input logic [63:0] t, input logic [2:0] bp,
                       input logic [4:0] hi, input logic [4:0] lo,
                       input string tag);
    exp_t e;
    @(negedge clk);
    start = 1'b1; op = o; rs = a; rt = t; bpos = bp; fmsb = hi; flsb = lo;
    e = model(o, a, t, bp, hi, lo);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && res_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected res_valid: actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        if (res_data !== e.data || illegal !== e.ill) begin
          fails++;
          $display("FAIL %s: actual data=%h ill=%b expected data=%h ill=%b",
                   e.tag, res_data, illegal, e.data, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset flags: actual v=%b i=%b expected v=0 i=0", res_valid, illegal);
    end
    rst = 1'b0;

    // R3 leading zeros
    issue(4'd0, 64'h0, 64'h0, 3'd0, 5'd0, 5'd0, "R3 clz zero word");
    issue(4'd0, 64'hFFFF_FFFF_0000_0000, 64'h0, 3'd0, 5'd0, 5'd0, "R3 clz upper ignored");
    issue(4'd0, 64'h1, 64'h0, 3'd0, 5'd0, 5'd0, "R3 clz one");
    issue(4'd0, 64'h8000_0000, 64'h0, 3'd0, 5'd0, 5'd0, "R3 clz top bit");
    // R4 extract
    issue(4'd1, 64'h0000_0000_1234_5678, 64'h0, 3'd0, 5'd7, 5'd4, "R4 extract byte");
    issue(4'd1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 3'd0, 5'd31, 5'd0, "R4 extract full word");
    issue(4'd1, 64'hFFFF_FFFF_8000_0000, 64'h0, 3'd0, 5'd0, 5'd31, "R4 extract single bit");
    issue(4'd1, 64'hF0F0_1234_5678_9ABC, 64'h0, 3'd0, 5'd19, 5'd13, "R4 extract mid");
    // R5 / R6 bit swaps
    issue(4'd2, 64'h0, 64'hFFFF_FFFF_0000_0001, 3'd0, 5'd0, 5'd0, "R5 bitswap word positive");
    issue(4'd2, 64'h0, 64'h0000_0000_0103_0C80, 3'd0, 5'd0, 5'd0, "R5 bitswap word negative");
    issue(4'd3, 64'h0, 64'h0102_0408_1020_4080, 3'd0, 5'd0, 5'd0, "R6 bitswap doubleword");
    issue(4'd3, 64'h0, 64'hA5C3_0F01_E7FE_3C81, 3'd0, 5'd0, 5'd0, "R6 bitswap mixed");
    idle();
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2 idle cycle: actual=%b expected=0", res_valid);
    end
    // R7 / R8 word align
    issue(4'd4, 64'h1111_1111_AABB_CCDD, 64'h2222_2222_8899_EEFF, 3'd0, 5'd0, 5'd0, "R7 align word b0");
    issue(4'd4, 64'h1111_1111_AABB_CCDD, 64'h2222_2222_8899_EEFF, 3'd4, 5'd0, 5'd0, "R7 align word bpos2 ignored");
    issue(4'd4, 64'h1111_1111_AABB_CCDD, 64'h2222_2222_0099_EEFF, 3'd1, 5'd0, 5'd0, "R8 align word b1");
    issue(4'd4, 64'h1111_1111_AABB_CCDD, 64'h2222_2222_8899_EEFF, 3'd2, 5'd0, 5'd0, "R8 align word b2");
    issue(4'd4, 64'h1111_1111_AABB_CCDD, 64'h2222_2222_8899_EE7F, 3'd3, 5'd0, 5'd0, "R8 align word b3");
    // R9 doubleword align
    issue(4'd5, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 3'd0, 5'd0, 5'd0, "R9 align dword b0");
    issue(4'd5, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 3'd1, 5'd0, 5'd0, "R9 align dword b1");
    issue(4'd5, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 3'd5, 5'd0, 5'd0, "R9 align dword b5");
    issue(4'd5, 64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 3'd7, 5'd0, 5'd0, "R9 align dword b7");
    // R10 rejected codes
    for (int c = 6; c < 16; c++)
      issue(4'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'h8765_4321_1234_5678, 3'd3, 5'd5, 5'd2, "R10 illegal op");
    // R2 back-to-back valid code after illegal
    issue(4'd3, 64'h0, 64'h0000_0000_0000_00FF, 3'd0, 5'd0, 5'd0, "R2 back-to-back after illegal");
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2 missing results: actual pending=%0d expected=0", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule